// File: doc/BRIEF.md
# Accumulator ALU with Condition-Code Flags

This block is the arithmetic heart of a small accumulator machine. Each cycle it receives the accumulator word and a memory operand. Every arithmetic circuit works on them at the same time: the sum, the difference, the operand incremented, the operand decremented, and a constant zero. An operation select then routes one of these candidates to the result port. The result is purely combinational and is valid in the same cycle as its inputs.

Next to the datapath sits a three-bit condition-code register holding greater-than, equal and less-than. A compare strobe, sampled on the rising clock edge, loads this register from a signed comparison of the operand against the accumulator. Later conditional branches read the flags. On any cycle without the strobe, the flags keep their value.

The select port has two forms, chosen by a parameter: a compact binary code or a one-hot vector. Data width is a parameter, 16 bits by default, in two's complement.

Top module: `acc_alu_cc`

## Requirements
- R1: With the binary select (default), code 0 drives the result with accumulator plus operand, wrapped modulo 2^WIDTH.
- R2: Code 1 drives the result with accumulator minus operand, wrapped modulo 2^WIDTH.
- R3: Code 2 drives the result with operand plus one, so 0xFFFF gives 0x0000.
- R4: Code 3 drives the result with operand minus one, so 0x0000 gives 0xFFFF.
- R5: Code 4 drives a zero result, and the unused codes 5, 6 and 7 also give zero. In one-hot form, bit i selects code i, and any select that is not exactly one bit gives zero.
- R6: The result depends only on the current accumulator, operand and select. It needs no clock edge and is not affected by the compare strobe or the flags.
- R7: On a rising edge with the compare strobe high, the flags are loaded as follows, with both words read as signed. The greater flag is 1 exactly when the operand is greater than the accumulator. The equal flag is 1 exactly when the two are equal. The less flag is 1 exactly when the operand is less than the accumulator.
- R8: After any compare, exactly one of the three flags is 1.
- R9: On a rising edge with the compare strobe low, the flags keep their value, whatever the data or select inputs do.
- R10: An active-low asynchronous reset clears all three flags to 0 without waiting for a clock edge.
- R11: A compare and a selected operation in the same cycle both take effect. The result shows the selected operation, and the flags take that cycle's comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| acc_in | input | WIDTH | Accumulator word |
| opnd_in | input | WIDTH | Memory operand word |
| op_sel | input | SEL_W | Operation select: 3-bit code, or 5-bit one-hot when ONEHOT_SEL=1 |
| cmp_stb | input | 1 | Loads the flags from the comparison at the next rising edge |
| result_o | output | WIDTH | Selected result |
| flag_gt | output | 1 | Operand was greater than the accumulator at the last compare |
| flag_eq | output | 1 | Operand equalled the accumulator at the last compare |
| flag_lt | output | 1 | Operand was less than the accumulator at the last compare |

## Verification
Two functions can fall in the same cycle: a combinational operation through the selector, and a flag update through the compare strobe. To exercise both together, the bench raises the strobe on each operand pair while a select code is applied, and it cycles that code through all eight values across the pairs. It judges the result in that same cycle against the arithmetic expected for that code. After the edge it judges the flags against a signed comparison of that pair. It then changes the data with the strobe low, to confirm the flags hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int NUM_OPS = 5;

   typedef enum int {
      OP_ADD = 0,
      OP_SUB = 1,
      OP_INC = 2,
      OP_DEC = 3,
      OP_CLR = 4
   } alu_op_e;

   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cc_t;

endpackage

// File: rtl/acc_alu_units.sv
module acc_alu_units
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]                acc_i,
   input  logic [WIDTH-1:0]                opnd_i,
   output logic [NUM_OPS-1:0][WIDTH-1:0]   cand_o,
   output cc_t                             cmp_o
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic signed [WIDTH-1:0] acc_s;
   logic signed [WIDTH-1:0] opnd_s;

   assign acc_s  = $signed(acc_i);
   assign opnd_s = $signed(opnd_i);

   // every circuit evaluates all the time; the selector chooses later
   always_comb begin
      cand_o         = '0;
      cand_o[OP_ADD] = acc_i + opnd_i;
      cand_o[OP_SUB] = acc_i - opnd_i;
      cand_o[OP_INC] = opnd_i + ONE;
      cand_o[OP_DEC] = opnd_i - ONE;
      cand_o[OP_CLR] = '0;
   end

   // operand is compared against the accumulator
   always_comb begin
      cmp_o.gt = (opnd_s >  acc_s);
      cmp_o.eq = (opnd_s == acc_s);
      cmp_o.lt = (opnd_s <  acc_s);
   end

endmodule

// File: rtl/acc_alu_sel.sv
module acc_alu_sel
   import acc_alu_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit ONEHOT_SEL = 1'b0,
   parameter int SEL_W      = 3
) (
   input  logic [SEL_W-1:0]                sel_i,
   input  logic [NUM_OPS-1:0][WIDTH-1:0]   cand_i,
   output logic [NUM_OPS-1:0]              hit_o,
   output logic [WIDTH-1:0]                res_o
);

   logic [NUM_OPS-1:0][SEL_W-1:0] match_code;

   generate
      for (genvar i = 0; i < NUM_OPS; i++) begin : g_code
         if (ONEHOT_SEL) begin : g_onehot
            assign match_code[i] = SEL_W'(1) << i;
         end else begin : g_binary
            assign match_code[i] = SEL_W'(i);
         end
      end
   endgenerate

   always_comb begin
      hit_o = '0;
      for (int i = 0; i < NUM_OPS; i++) begin
         hit_o[i] = (sel_i == match_code[i]);
      end
   end

   always_comb begin
      res_o = '0;
      for (int i = 0; i < NUM_OPS; i++) begin
         if (hit_o[i]) res_o = cand_i[i];
      end
   end

endmodule

// File: rtl/acc_alu_ccreg.sv
module acc_alu_ccreg
   import acc_alu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  cc_t  cmp_i,
   output cc_t  cc_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cc_o <= '0;
      else if (load_i) cc_o <= cmp_i;
   end

   // R8
   cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> ($countones(cc_o) == 1));

   // R9
   cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(cc_o));

   // R10
   cc_reset_chk: assert property (@(posedge clk)
      !rst_n |-> (cc_o == '0));

endmodule

// File: rtl/acc_alu_cc.sv
module acc_alu_cc
   import acc_alu_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit ONEHOT_SEL = 1'b0,
   localparam int SEL_W     = ONEHOT_SEL ? NUM_OPS : $clog2(NUM_OPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] acc_in,
   input  logic [WIDTH-1:0] opnd_in,
   input  logic [SEL_W-1:0] op_sel,
   input  logic             cmp_stb,
   output logic [WIDTH-1:0] result_o,
   output logic             flag_gt,
   output logic             flag_eq,
   output logic             flag_lt
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("acc_alu_cc: WIDTH must be at least 2");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("acc_alu_cc: select width must be positive");
      end
   endgenerate

   logic [NUM_OPS-1:0][WIDTH-1:0] cand;
   logic [NUM_OPS-1:0]            hit;
   cc_t                           cmp_now;
   cc_t                           cc_q;

   acc_alu_units #(.WIDTH(WIDTH)) u_units (
      .acc_i  (acc_in),
      .opnd_i (opnd_in),
      .cand_o (cand),
      .cmp_o  (cmp_now)
   );

   acc_alu_sel #(.WIDTH(WIDTH), .ONEHOT_SEL(ONEHOT_SEL), .SEL_W(SEL_W)) u_sel (
      .sel_i  (op_sel),
      .cand_i (cand),
      .hit_o  (hit),
      .res_o  (result_o)
   );

   acc_alu_ccreg u_ccreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (cmp_stb),
      .cmp_i  (cmp_now),
      .cc_o   (cc_q)
   );

   assign flag_gt = cc_q.gt;
   assign flag_eq = cc_q.eq;
   assign flag_lt = cc_q.lt;

   // R5
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   // R1
   add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[OP_ADD] |-> (result_o - opnd_in == acc_in));

   // R2
   sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[OP_SUB] |-> (result_o + opnd_in == acc_in));

   // R3
   inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[OP_INC] |-> (result_o - ONE == opnd_in));

   // R4
   dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[OP_DEC] |-> (result_o + ONE == opnd_in));

   // R5
   zero_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[OP_CLR] || hit == '0) |-> (result_o == '0));

   // R7
   cmp_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_stb |=> (flag_eq == ($past(acc_in) == $past(opnd_in))));

endmodule

// File: tb/acc_alu_cc_tb.sv
module acc_alu_cc_tb;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] acc_in = '0;
   logic [W-1:0] opnd_in = '0;
   logic [2:0]   op_sel = '0;
   logic         cmp_stb = 1'b0;
   logic [W-1:0] result_o;
   logic         flag_gt, flag_eq, flag_lt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [2:0] exp_cc = 3'b000;

   always #10 clk = ~clk;

   acc_alu_cc u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_in   (acc_in),
      .opnd_in  (opnd_in),
      .op_sel   (op_sel),
      .cmp_stb  (cmp_stb),
      .result_o (result_o),
      .flag_gt  (flag_gt),
      .flag_eq  (flag_eq),
      .flag_lt  (flag_lt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_res(input logic [2:0] op,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
      case (op)
         3'd0:    return W'((32'(a) + 32'(b)) % 65536);
         3'd1:    return W'((32'(a) + 65536 - 32'(b)) % 65536);
         3'd2:    return W'((32'(b) + 1) % 65536);
         3'd3:    return W'((32'(b) + 65535) % 65536);
         default: return '0;
      endcase
   endfunction

   function automatic logic [2:0] exp_flags(input logic [W-1:0] a, input logic [W-1:0] b);
      int sa = $signed(a);
      int sb = $signed(b);
      return {sb > sa, sb == sa, sb < sa};
   endfunction

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         default: return "R5";
      endcase
   endfunction

   function automatic logic [W-1:0] corner(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'h0002;
         3: return 16'h7FFF;
         4: return 16'h8000;
         5: return 16'h8001;
         6: return 16'hFFFF;
         7: return 16'hFFFE;
         8: return 16'h1234;
         default: return 16'h00FF;
      endcase
   endfunction

   task automatic do_pair(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] op0);
      // compare plus operation in the same cycle (R11)
      @(negedge clk);
      acc_in = a; opnd_in = b; op_sel = op0; cmp_stb = 1'b1;
      #1;
      chk("R11 result during compare", 32'(result_o), 32'(exp_res(op0, a, b)));
      @(negedge clk);
      cmp_stb = 1'b0;
      exp_cc = exp_flags(a, b);
      chk("R7 flags", {29'd0, flag_gt, flag_eq, flag_lt}, {29'd0, exp_cc});
      chk("R8 one flag set", 32'($countones({flag_gt, flag_eq, flag_lt})), 32'd1);
      // all select codes, no clock edge needed (R6)
      for (int o = 0; o < 8; o++) begin
         op_sel = 3'(o);
         #1;
         chk(req_of(3'(o)), 32'(result_o), 32'(exp_res(3'(o), a, b)));
      end
      // data changes with strobe low: flags hold (R9)
      acc_in = b; opnd_in = ~a;
      @(negedge clk);
      chk("R9 flags hold", {29'd0, flag_gt, flag_eq, flag_lt}, {29'd0, exp_cc});
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #1;
      chk("R10 flags in reset", {29'd0, flag_gt, flag_eq, flag_lt}, 32'd0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 flags after reset", {29'd0, flag_gt, flag_eq, flag_lt}, 32'd0);

      for (int i = 0; i < 10; i++) begin
         for (int j = 0; j < 10; j++) begin
            do_pair(corner(i), corner(j), 3'((i * 10 + j) % 8));
         end
      end

      // pseudo-random pairs
      begin
         logic [W-1:0] x = 16'hACE1;
         for (int k = 0; k < 200; k++) begin
            logic [W-1:0] y;
            x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
            y = x ^ 16'h5A3C ^ W'(k * 977);
            do_pair(x, (k % 7 == 0) ? x : y, 3'(k % 8));
         end
      end

      // asynchronous reset mid-run (R10)
      @(negedge clk);
      acc_in = 16'h0001; opnd_in = 16'h0005; cmp_stb = 1'b1;
      @(negedge clk);
      cmp_stb = 1'b0;
      chk("R7 gt before reset", {31'd0, flag_gt}, 32'd1);
      #3;
      rst_n = 1'b0;
      #1;
      chk("R10 async clear", {29'd0, flag_gt, flag_eq, flag_lt}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 stays clear", {29'd0, flag_gt, flag_eq, flag_lt}, 32'd0);

      finish_up();
   end

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
   end

endmodule